// File: doc/BRIEF.md
# Latency Tolerance Threshold Evaluator

This block keeps the latest latency-tolerance report sent by a downstream device and decides whether the link may drop into the deepest L1 substate. Each report has two fields, one for snoop traffic and one for no-snoop traffic. Every field holds a requirement flag, a 10-bit latency value and a 3-bit scale. The block turns each field's value and scale into a latency in nanoseconds. It does the same for a programmed threshold and compares each traffic class against it separately. A class with no requirement passes without a compare. The eligible flag goes to the substate controller and is high only when both classes pass.

A report that arrives while the mechanism is unsupported or disabled is not stored. Instead, the block raises a one-cycle unsupported-request pulse. Stored values stay in registers until the next accepted report. After reset, both classes hold "no requirement".

Top module: `ltr_threshold_eval`

## Requirements
- R1: After reset, `l12_eligible` is 1, `unsup_req` is 0, and both stored classes hold "no requirement".
- R2: A report field is 14 bits. Bit 13 is the requirement flag (1 = requirement present), bits 12:10 are the scale and bits 9:0 are the value. Latency in ns is value × 2^(5×scale), and any scale above 5 is treated as 5. When the flag is 0, the value and scale have no effect.
- R3: The snoop class passes when its stored flag is 0 or its latency is greater than or equal to the threshold latency.
- R4: The no-snoop class passes under the same rule, independent of the snoop result.
- R5: `l12_eligible` is 1 exactly when both classes pass, so a report with both flags clear makes the link eligible.
- R6: A report is accepted when `rpt_valid` is high and both `ltr_supported` and `ltr_enabled` are high. From the cycle after that rising edge, the outputs reflect the new report.
- R7: A report that arrives while `ltr_supported` or `ltr_enabled` is low raises `unsup_req` for exactly the next cycle and leaves the stored report, and so `l12_eligible`, unchanged.
- R8: With `rpt_valid` low, the stored report is held and `l12_eligible` changes only if the threshold changes.
- R9: The threshold uses the same value, scale and clamping as a field. A change to `thr_value` or `thr_scale` shows in `l12_eligible` in the same cycle.
- R10: The compare is wide enough that the largest report (value 1023, scale 7) and the largest threshold compare without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | One-cycle strobe marking a report |
| snoop_fld | input | 14 | Snoop field {flag, scale, value} |
| nosnoop_fld | input | 14 | No-snoop field {flag, scale, value} |
| thr_value | input | 10 | Threshold value |
| thr_scale | input | 3 | Threshold scale |
| ltr_supported | input | 1 | Mechanism is supported |
| ltr_enabled | input | 1 | Mechanism is enabled |
| l12_eligible | output | 1 | Both traffic classes meet the threshold |
| unsup_req | output | 1 | Pulse: a report arrived while unsupported or disabled |

## Verification
A report sampled on one rising edge changes the stored state at that edge. As a result, both `l12_eligible` and `unsup_req` take their new values one edge later than the report strobe, counting from the negative edge where it is driven. A threshold change passes only through combinational logic, so its effect is due in the same cycle. The driver applies every stimulus on a falling edge and queues the expected pair at that moment. The monitor pops and compares that pair 2 ns after the next rising edge, which is the first point where either kind of result is valid.

// File: rtl/ltr_eval_pkg.sv
package ltr_eval_pkg;

    localparam int unsigned VALUE_W    = 10;
    localparam int unsigned SCALE_W    = 3;
    localparam int unsigned SCALE_STEP = 5;
    localparam int unsigned SCALE_MAX  = 5;
    localparam int unsigned NUM_CLASS  = 2;

    localparam int unsigned FIELD_W = 1 + SCALE_W + VALUE_W;
    localparam int unsigned LAT_W   = VALUE_W + SCALE_STEP * SCALE_MAX;

    localparam int unsigned CLS_SNOOP   = 0;
    localparam int unsigned CLS_NOSNOOP = 1;

    typedef logic [VALUE_W-1:0] lat_value_t;
    typedef logic [SCALE_W-1:0] lat_scale_t;
    typedef logic [LAT_W-1:0]   lat_ns_t;

    // Flag in the top bit, then scale, then value.
    typedef struct packed {
        logic       req;
        lat_scale_t scale;
        lat_value_t value;
    } ltr_field_t;

    function automatic lat_scale_t clamp_scale(lat_scale_t s);
        if (s > lat_scale_t'(SCALE_MAX)) begin
            return lat_scale_t'(SCALE_MAX);
        end
        return s;
    endfunction

    function automatic lat_ns_t norm_latency(lat_value_t v, lat_scale_t s);
        lat_scale_t eff;
        eff = clamp_scale(s);
        return lat_ns_t'(v) << (SCALE_STEP * eff);
    endfunction

endpackage

// File: rtl/ltr_lat_decode.sv
module ltr_lat_decode
    import ltr_eval_pkg::*;
(
    input  lat_value_t value_i,
    input  lat_scale_t scale_i,
    output lat_ns_t    lat_o
);

    always_comb begin
        lat_o = norm_latency(value_i, scale_i);
    end

endmodule

// File: rtl/ltr_class_cmp.sv
module ltr_class_cmp
    import ltr_eval_pkg::*;
(
    input  ltr_field_t fld_i,
    input  lat_ns_t    thr_lat_i,
    output logic       pass_o
);

    lat_ns_t fld_lat;

    ltr_lat_decode u_dec (
        .value_i (fld_i.value),
        .scale_i (fld_i.scale),
        .lat_o   (fld_lat)
    );

    // No requirement means the class tolerates any latency.
    always_comb begin
        pass_o = (!fld_i.req) || (fld_lat >= thr_lat_i);
    end

endmodule

// File: rtl/ltr_report_store.sv
module ltr_report_store
    import ltr_eval_pkg::*;
#(
    parameter int unsigned N = NUM_CLASS
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rpt_valid_i,
    input  logic                   accept_ok_i,
    input  ltr_field_t [N-1:0]     fields_i,
    output ltr_field_t [N-1:0]     stored_o,
    output logic                   unsup_o
);

    logic take;
    logic refuse;

    always_comb begin
        take   = rpt_valid_i && accept_ok_i;
        refuse = rpt_valid_i && !accept_ok_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unsup_o <= 1'b0;
        end else begin
            unsup_o <= refuse;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                stored_o[g] <= '0;
            end else if (take) begin
                stored_o[g] <= fields_i[g];
            end
        end
    end

endmodule

// File: rtl/ltr_threshold_eval.sv
module ltr_threshold_eval
    import ltr_eval_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rpt_valid,
    input  logic [FIELD_W-1:0] snoop_fld,
    input  logic [FIELD_W-1:0] nosnoop_fld,
    input  logic [VALUE_W-1:0] thr_value,
    input  logic [SCALE_W-1:0] thr_scale,
    input  logic               ltr_supported,
    input  logic               ltr_enabled,
    output logic               l12_eligible,
    output logic               unsup_req
);

    ltr_field_t [NUM_CLASS-1:0] in_fld;
    ltr_field_t [NUM_CLASS-1:0] stored_q;
    logic       [NUM_CLASS-1:0] class_pass;
    lat_ns_t                    thr_lat;
    logic                       accept_ok;

    always_comb begin
        in_fld[CLS_SNOOP]   = ltr_field_t'(snoop_fld);
        in_fld[CLS_NOSNOOP] = ltr_field_t'(nosnoop_fld);
        accept_ok           = ltr_supported && ltr_enabled;
    end

    ltr_report_store #(.N(NUM_CLASS)) u_store (
        .clk         (clk),
        .rst         (rst),
        .rpt_valid_i (rpt_valid),
        .accept_ok_i (accept_ok),
        .fields_i    (in_fld),
        .stored_o    (stored_q),
        .unsup_o     (unsup_req)
    );

    ltr_lat_decode u_thr_dec (
        .value_i (thr_value),
        .scale_i (thr_scale),
        .lat_o   (thr_lat)
    );

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cls
        ltr_class_cmp u_cmp (
            .fld_i     (stored_q[g]),
            .thr_lat_i (thr_lat),
            .pass_o    (class_pass[g])
        );
    end

    always_comb begin
        l12_eligible = &class_pass;
    end

endmodule

// File: rtl/ltr_eval_chk.sv
module ltr_eval_chk
    import ltr_eval_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       rpt_valid,
    input logic                       ltr_supported,
    input logic                       ltr_enabled,
    input logic                       unsup_req,
    input logic                       l12_eligible,
    input ltr_field_t [NUM_CLASS-1:0] stored,
    input logic       [NUM_CLASS-1:0] class_pass
);

    // R7
    unsup_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && !(ltr_supported && ltr_enabled)) |=> unsup_req);

    // R6
    no_false_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !(rpt_valid && !(ltr_supported && ltr_enabled)) |=> !unsup_req);

    // R7
    blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && !(ltr_supported && ltr_enabled)) |=> $stable(stored));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rpt_valid |=> $stable(stored));

    // R3
    snoop_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        !stored[CLS_SNOOP].req |-> class_pass[CLS_SNOOP]);

    // R4
    nosnoop_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        !stored[CLS_NOSNOOP].req |-> class_pass[CLS_NOSNOOP]);

    // R5
    blocked_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !l12_eligible |-> (stored[CLS_SNOOP].req || stored[CLS_NOSNOOP].req));

endmodule

bind ltr_threshold_eval ltr_eval_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rpt_valid     (rpt_valid),
    .ltr_supported (ltr_supported),
    .ltr_enabled   (ltr_enabled),
    .unsup_req     (unsup_req),
    .l12_eligible  (l12_eligible),
    .stored        (stored_q),
    .class_pass    (class_pass)
);

// File: tb/sim_ltr_threshold_eval.sv
module sim_ltr_threshold_eval;

    logic        clk = 1'b0;
    logic        rst;
    logic        rpt_valid;
    logic [13:0] snoop_fld;
    logic [13:0] nosnoop_fld;
    logic [9:0]  thr_value;
    logic [2:0]  thr_scale;
    logic        ltr_supported;
    logic        ltr_enabled;
    logic        l12_eligible;
    logic        unsup_req;

    always #5 clk = ~clk;

    ltr_threshold_eval u0 (
        .clk           (clk),
        .rst           (rst),
        .rpt_valid     (rpt_valid),
        .snoop_fld     (snoop_fld),
        .nosnoop_fld   (nosnoop_fld),
        .thr_value     (thr_value),
        .thr_scale     (thr_scale),
        .ltr_supported (ltr_supported),
        .ltr_enabled   (ltr_enabled),
        .l12_eligible  (l12_eligible),
        .unsup_req     (unsup_req)
    );

    typedef struct {
        logic  elig;
        logic  unsup;
        string tag;
    } exp_t;

    exp_t        exp_q[$];
    int          nvec  = 0;
    int          nfail = 0;
    logic        done  = 1'b0;
    logic [13:0] m_snoop = '0;
    logic [13:0] m_nosnoop = '0;

    // R2 layout: {flag[13], scale[12:10], value[9:0]}
    function automatic logic [13:0] fld(input logic req, input logic [2:0] sc, input logic [9:0] v);
        return {req, sc, v};
    endfunction

    function automatic longint lat(input logic [9:0] v, input logic [2:0] sc);
        int e;
        e = (sc > 3'd5) ? 5 : int'(sc);
        return longint'(v) * (longint'(1) << (5 * e));
    endfunction

    function automatic logic cls_pass(input logic [13:0] f);
        return (!f[13]) || (lat(f[9:0], f[12:10]) >= lat(thr_value, thr_scale));
    endfunction

    function automatic logic model_elig();
        return cls_pass(m_snoop) && cls_pass(m_nosnoop);
    endfunction

    task automatic report(input logic [13:0] s, input logic [13:0] n,
                          input logic sup, input logic en, input string tag);
        @(negedge clk);
        snoop_fld     = s;
        nosnoop_fld   = n;
        ltr_supported = sup;
        ltr_enabled   = en;
        rpt_valid     = 1'b1;
        if (sup && en) begin
            m_snoop   = s;
            m_nosnoop = n;
        end
        exp_q.push_back('{model_elig(), !(sup && en), tag});
        @(negedge clk);
        rpt_valid     = 1'b0;
        ltr_supported = 1'b1;
        ltr_enabled   = 1'b1;
    endtask

    task automatic set_thr(input logic [9:0] v, input logic [2:0] sc, input string tag);
        @(negedge clk);
        thr_value = v;
        thr_scale = sc;
        exp_q.push_back('{model_elig(), 1'b0, tag});
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        exp_q.push_back('{model_elig(), 1'b0, tag});
        @(negedge clk);
    endtask

    // Monitor: compare 2 ns after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (!rst && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            nvec++;
            if (l12_eligible !== e.elig || unsup_req !== e.unsup) begin
                nfail++;
                $display("FAIL %s: eligible=%0b unsup=%0b, expected eligible=%0b unsup=%0b",
                         e.tag, l12_eligible, unsup_req, e.elig, e.unsup);
            end
        end
    end

    initial begin
        rst = 1'b1; rpt_valid = 1'b0; snoop_fld = '0; nosnoop_fld = '0;
        thr_value = 10'd100; thr_scale = 3'd1;
        ltr_supported = 1'b1; ltr_enabled = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nvec++;
        if (l12_eligible !== 1'b1 || unsup_req !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset: eligible=%0b unsup=%0b, expected eligible=1 unsup=0",
                     l12_eligible, unsup_req);
        end
        // threshold 100 x 32 = 3200 ns
        report(fld(1,1,150), fld(0,0,0), 1, 1, "R3 snoop above");
        report(fld(1,1,99),  fld(0,0,0), 1, 1, "R3 snoop below");
        report(fld(0,7,1023), fld(1,1,50), 1, 1, "R4 nosnoop below");
        report(fld(1,1,100), fld(1,1,100), 1, 1, "R5 both equal");
        report(fld(0,3,5),   fld(0,6,1),  1, 1, "R5 R2 both flags clear");
        report(fld(1,0,1),   fld(1,0,1),  1, 1, "R5 both below");
        report(fld(1,1,200), fld(1,1,200), 1, 0, "R7 disabled");
        report(fld(1,1,200), fld(1,1,200), 0, 1, "R7 unsupported");
        idle("R8 hold low");
        report(fld(1,1,200), fld(0,0,0), 1, 1, "R6 accepted");
        idle("R8 hold high");
        set_thr(10'd1, 3'd5, "R9 threshold raise");
        report(fld(1,7,1), fld(0,0,0), 1, 1, "R2 report scale clamp");
        set_thr(10'd2, 3'd5, "R2 clamp above");
        set_thr(10'd1, 3'd7, "R9 threshold scale clamp");
        set_thr(10'd1023, 3'd5, "R10 max threshold");
        report(fld(1,7,1023), fld(1,6,1023), 1, 1, "R10 max equal");
        report(fld(1,7,1022), fld(0,0,0), 1, 1, "R10 max minus one");
        set_thr(10'd31, 3'd0, "R9 small threshold");
        report(fld(1,1,1), fld(0,0,0), 1, 1, "R2 cross scale pass");
        set_thr(10'd33, 3'd0, "R2 cross scale fail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule